// File: doc/BRIEF.md
# SPI Slave Serializer with Character Retransmit

This block is the slave side of an SPI link, clocked by a fast system clock. The external serial clock, select and data-in lines pass through two-flop synchronizers, and all edge detection happens in the system clock domain. While select is held low, the block moves a word of programmable length, one to sixteen bits and most significant bit first. The word is shifted in from the data-in line and out onto the data-out line. Clock polarity and phase are both selectable.

A processor reaches the block through a small synchronous register port. The port holds a configuration word, a transmit holding register, a receive register and a status word. Received bits replace the outgoing bits in the shift register as they arrive. If software supplies no new transmit value, the block therefore sends back the character it last received. When software writes several transmit values before a transfer begins, only the newest one is sent.

The register port decodes `addr` as follows. 0 is configuration, read and write. 1 is transmit, write only. 2 is receive, read only. 3 is status, read only. Read data appears on `rdata` on the clock edge that samples `rd_en`.

Top module: `spis_retx_slave`

## Requirements
- R1: After reset, status reads 0x0001: transmit-empty (bit 0) set, receive-full (bit 1) clear, overrun (bit 2) clear. The configuration selects 8 bits, idle-low clock and capture on the leading edge, and the first transfer sends all zeros.
- R2: The configuration register holds the word length minus one in bits [3:0], so a transfer moves that value plus one bits. Data moves most significant bit first on both data lines.
- R3: With the phase flag (configuration bit 5) at 1, data-in is captured on the leading clock edge and data-out changes on the trailing edge. Configuration bit 4 sets the idle level of the clock, and the block works at either idle level.
- R4: With the phase flag at 0, data-out changes on the leading clock edge and data-in is captured on the trailing edge, at either idle level.
- R5: Clock edges while select is high have no effect: no word completes and the receive-full flag is unchanged.
- R6: When the last bit of a word is captured, the word is placed in the receive register and receive-full sets. A read of the receive register clears receive-full.
- R7: If a word completes while receive-full is still set, overrun sets. The receive register still takes the newer word.
- R8: A read of the status register clears overrun.
- R9: A transmit write is copied straight into the shift register, with transmit-empty staying at 1, when three conditions all hold: nothing is pending, the shift register holds no unsent written value, and no word is in progress. The written value is then the next word sent.
- R10: Any other transmit write is held, and transmit-empty reads 0. Further writes overwrite the held value. When select falls, or a word completes, the held value is loaded into the shift register and transmit-empty returns to 1. Any earlier directly loaded value is discarded.
- R11: When no transmit value has been written since the last load, the next transfer sends back the last received character.
- R12: Select rising in the middle of a word resets the bit counter, leaves the receive register and receive-full untouched, and leaves any loaded transmit value counted as unsent. The next full word is received correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spck | input | 1 | Serial clock from the master, asynchronous |
| nss | input | 1 | Active-low slave select, asynchronous |
| mosi | input | 1 | Serial data in, asynchronous |
| miso | output | 1 | Serial data out, registered |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 2 | Register select: 0 config, 1 transmit, 2 receive, 3 status |
| wdata | input | 16 | Register write data |
| rdata | output | 16 | Registered read data |

## Verification
The hardest situation to reach is a transmit value that is held rather than loaded. The shift register must first contain a directly written value that has not yet been sent. Only then will a second and a third write queue up in the holding register instead of taking the direct path. The bench reaches this by writing three values in a row while select is idle. It then checks, at the master end, that only the third value goes out.

A second hard case is the mid-word abort. The bench raises select after three bits, checks that no receive word appears, and then confirms that a held write still goes out on the next full word.

// File: rtl/spis_pkg.sv
package spis_pkg;

  typedef enum logic [1:0] {
    REG_CFG  = 2'd0,
    REG_TX   = 2'd1,
    REG_RX   = 2'd2,
    REG_STAT = 2'd3
  } reg_addr_e;

  localparam int ST_TX_EMPTY = 0;
  localparam int ST_RX_FULL  = 1;
  localparam int ST_OVERRUN  = 2;

endpackage

// File: rtl/spis_sync.sv
module spis_sync #(
  parameter int          WIDTH   = 3,
  parameter int          STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] chain [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) chain[g] <= RST_VAL;
        else     chain[g] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) chain[g] <= RST_VAL;
        else     chain[g] <= chain[g-1];
      end
    end
  end

  assign dout = chain[STAGES-1];

endmodule

// File: rtl/spis_shifter.sv
module spis_shifter #(
  parameter int MAX_BITS = 16,
  parameter int LEN_W    = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                sck_s,
  input  logic                nss_s,
  input  logic                mosi_s,
  input  logic [LEN_W-1:0]    len_m1,
  input  logic                cpol,
  input  logic                ncpha,
  input  logic                load_en,
  input  logic [MAX_BITS-1:0] load_data,
  output logic                miso,
  output logic                nss_fall,
  output logic                busy,
  output logic                done,
  output logic [MAX_BITS-1:0] rx_word
);

  logic                sck_prev, nss_prev;
  logic [MAX_BITS-1:0] sr, shifted, mask;
  logic [LEN_W-1:0]    cnt;
  logic                act, sck_rise, sck_fall, lead, trail, cap, chg, last;

  always_comb begin
    act      = !nss_s;
    sck_rise = sck_s && !sck_prev;
    sck_fall = !sck_s && sck_prev;
    lead     = cpol ? sck_fall : sck_rise;
    trail    = cpol ? sck_rise : sck_fall;
    cap      = act && (ncpha ? lead : trail);
    chg      = act && (ncpha ? trail : lead);
    for (int i = 0; i < MAX_BITS; i++) mask[i] = (i <= int'(len_m1));
    shifted  = ((sr << 1) | {{(MAX_BITS-1){1'b0}}, mosi_s}) & mask;
    last     = (cnt == len_m1);
  end

  assign nss_fall = nss_prev && !nss_s;
  assign busy     = (cnt != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_prev <= 1'b0;
      nss_prev <= 1'b1;
      sr       <= '0;
      cnt      <= '0;
      miso     <= 1'b0;
      done     <= 1'b0;
      rx_word  <= '0;
    end else begin
      sck_prev <= sck_s;
      nss_prev <= nss_s;
      done     <= 1'b0;
      if (!act) begin
        cnt <= '0;
      end else if (cap) begin
        sr <= shifted;
        if (last) begin
          cnt     <= '0;
          done    <= 1'b1;
          rx_word <= shifted;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
      if (load_en) sr <= load_data & mask;
      if (chg) miso <= sr[len_m1];
      else if (ncpha && cnt == '0 && !cap) miso <= sr[len_m1];
    end
  end

  // R12: an inactive select always returns the bit counter to zero
  a_r12_cnt_cleared: assert property (@(posedge clk) disable iff (rst)
    !act |=> (cnt == '0));

  // R5: no word can complete out of a cycle with select inactive
  a_r5_no_done_idle: assert property (@(posedge clk) disable iff (rst)
    !act |=> !done);

  // R2: counter never passes the programmed length
  a_r2_cnt_bound: assert property (@(posedge clk) disable iff (rst)
    $stable(len_m1) |-> (cnt <= len_m1));

endmodule

// File: rtl/spis_regs.sv
module spis_regs
  import spis_pkg::*;
#(
  parameter int MAX_BITS = 16,
  parameter int LEN_W    = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic                rd_en,
  input  reg_addr_e           addr,
  input  logic [MAX_BITS-1:0] wdata,
  output logic [MAX_BITS-1:0] rdata,
  input  logic                nss_fall,
  input  logic                busy,
  input  logic                done,
  input  logic [MAX_BITS-1:0] rx_word,
  output logic [LEN_W-1:0]    len_m1,
  output logic                cpol,
  output logic                ncpha,
  output logic                load_en,
  output logic [MAX_BITS-1:0] load_data
);

  localparam int CFG_W = LEN_W + 2;

  logic [MAX_BITS-1:0] tdr, rdr;
  logic                pending, fresh, rx_full, ovr;
  logic                wr_tx, rd_rx, rd_st, load_pt, direct;
  logic [MAX_BITS-1:0] status, cfg_word;

  always_comb begin
    wr_tx    = wr_en && (addr == REG_TX);
    rd_rx    = rd_en && (addr == REG_RX);
    rd_st    = rd_en && (addr == REG_STAT);
    load_pt  = nss_fall || done;
    direct   = wr_tx && (load_pt || (!pending && !fresh && !busy));
    load_en  = 1'b0;
    load_data = wdata;
    if (direct) begin
      load_en = 1'b1;
    end else if (load_pt && pending) begin
      load_en   = 1'b1;
      load_data = tdr;
    end
    status = '0;
    status[ST_TX_EMPTY] = !pending;
    status[ST_RX_FULL]  = rx_full;
    status[ST_OVERRUN]  = ovr;
    cfg_word = '0;
    cfg_word[CFG_W-1:0] = {ncpha, cpol, len_m1};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tdr     <= '0;
      rdr     <= '0;
      pending <= 1'b0;
      fresh   <= 1'b0;
      rx_full <= 1'b0;
      ovr     <= 1'b0;
      len_m1  <= LEN_W'(7);
      cpol    <= 1'b0;
      ncpha   <= 1'b1;
      rdata   <= '0;
    end else begin
      if (wr_en && addr == REG_CFG) {ncpha, cpol, len_m1} <= wdata[CFG_W-1:0];
      if (wr_tx) tdr <= wdata;

      if (wr_tx && !direct) pending <= 1'b1;
      else if (load_pt)     pending <= 1'b0;

      if (load_en)   fresh <= 1'b1;
      else if (done) fresh <= 1'b0;

      if (done) begin
        rdr     <= rx_word;
        rx_full <= 1'b1;
      end else if (rd_rx) begin
        rx_full <= 1'b0;
      end

      if (done && rx_full && !rd_rx) ovr <= 1'b1;
      else if (rd_st)                ovr <= 1'b0;

      if (rd_en) begin
        case (addr)
          REG_CFG:  rdata <= cfg_word;
          REG_TX:   rdata <= tdr;
          REG_RX:   rdata <= rdr;
          default:  rdata <= status;
        endcase
      end
    end
  end

  // R7: overrun only appears when an unread word was already present
  a_r7_ovr_needs_full: assert property (@(posedge clk) disable iff (rst)
    $rose(ovr) |-> $past(rx_full));

  // R8: status read clears overrun unless a word completes at once
  a_r8_ovr_clear: assert property (@(posedge clk) disable iff (rst)
    (rd_st && !done) |=> !ovr);

  // R6: a completed word always leaves receive-full set
  a_r6_full_after_done: assert property (@(posedge clk) disable iff (rst)
    done |=> rx_full);

  // R10: a held value is consumed at a load point
  a_r10_pending_loaded: assert property (@(posedge clk) disable iff (rst)
    (load_pt && pending && !wr_tx) |=> (!pending && fresh));

  // R9: a direct write never leaves anything held
  a_r9_direct_empty: assert property (@(posedge clk) disable iff (rst)
    (direct && !pending) |=> !pending);

endmodule

// File: rtl/spis_retx_slave.sv
module spis_retx_slave
  import spis_pkg::*;
#(
  parameter int MAX_BITS    = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                spck,
  input  logic                nss,
  input  logic                mosi,
  output logic                miso,
  input  logic                wr_en,
  input  logic                rd_en,
  input  logic [1:0]          addr,
  input  logic [MAX_BITS-1:0] wdata,
  output logic [MAX_BITS-1:0] rdata
);

  localparam int LEN_W = $clog2(MAX_BITS);

  logic [2:0]          sync_out;
  logic                sck_s, nss_s, mosi_s;
  logic [LEN_W-1:0]    len_m1;
  logic                cpol, ncpha, load_en, nss_fall, busy, done;
  logic [MAX_BITS-1:0] load_data, rx_word;

  spis_sync #(
    .WIDTH  (3),
    .STAGES (SYNC_STAGES),
    .RST_VAL(3'b010)
  ) i_sync (
    .clk (clk),
    .rst (rst),
    .din ({mosi, nss, spck}),
    .dout(sync_out)
  );

  assign {mosi_s, nss_s, sck_s} = sync_out;

  spis_shifter #(
    .MAX_BITS(MAX_BITS),
    .LEN_W   (LEN_W)
  ) i_shifter (
    .clk      (clk),
    .rst      (rst),
    .sck_s    (sck_s),
    .nss_s    (nss_s),
    .mosi_s   (mosi_s),
    .len_m1   (len_m1),
    .cpol     (cpol),
    .ncpha    (ncpha),
    .load_en  (load_en),
    .load_data(load_data),
    .miso     (miso),
    .nss_fall (nss_fall),
    .busy     (busy),
    .done     (done),
    .rx_word  (rx_word)
  );

  spis_regs #(
    .MAX_BITS(MAX_BITS),
    .LEN_W   (LEN_W)
  ) i_regs (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .addr     (reg_addr_e'(addr)),
    .wdata    (wdata),
    .rdata    (rdata),
    .nss_fall (nss_fall),
    .busy     (busy),
    .done     (done),
    .rx_word  (rx_word),
    .len_m1   (len_m1),
    .cpol     (cpol),
    .ncpha    (ncpha),
    .load_en  (load_en),
    .load_data(load_data)
  );

endmodule

// File: tb/test_spis_retx_slave.sv
module test_spis_retx_slave;

  localparam time CLK_PERIOD = 10ns;
  localparam int  HALF       = 8;
  localparam int  W          = 16;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         spck = 1'b0, nss = 1'b1, mosi = 1'b0;
  logic         miso;
  logic         wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0]   addr = '0;
  logic [W-1:0] wdata = '0;
  logic [W-1:0] rdata;

  int total = 0;
  int bad   = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spis_retx_slave i_spis_retx_slave (
    .clk(clk), .rst(rst), .spck(spck), .nss(nss), .mosi(mosi), .miso(miso),
    .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata)
  );

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=0x%04h expected=0x%04h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [W-1:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [W-1:0] d);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  // master side: stop < n aborts the word after that many bits
  task automatic spi_xfer(input int n, input logic cp, input logic ph,
                          input logic [W-1:0] mo, input int stop,
                          output logic [W-1:0] got);
    got = '0;
    spck = cp;
    wait_clk(HALF);
    nss = 1'b0;
    if (ph) mosi = mo[n-1];
    wait_clk(HALF);
    for (int i = 0; i < n; i++) begin
      if (ph) begin
        got[n-1-i] = miso;
        spck = ~cp;
        wait_clk(HALF);
        spck = cp;
        if (i < n-1) mosi = mo[n-2-i];
        wait_clk(HALF);
      end else begin
        spck = ~cp;
        mosi = mo[n-1-i];
        wait_clk(HALF);
        got[n-1-i] = miso;
        spck = cp;
        wait_clk(HALF);
      end
      if (i + 1 == stop) break;
    end
    nss = 1'b1;
    wait_clk(2*HALF);
  endtask

  task automatic t_reset;
    logic [W-1:0] d, got;
    rd_reg(2'd3, d);
    check("R1 status after reset", d, 16'h0001);
    rd_reg(2'd0, d);
    check("R1 config after reset", d, 16'h0027);
    spi_xfer(8, 1'b0, 1'b1, 16'h00A5, 99, got);
    check("R1 first transfer sends zeros", got, 16'h0000);
    rd_reg(2'd3, d);
    check("R6 receive-full after word", d, 16'h0003);
    rd_reg(2'd2, d);
    check("R6 received word", d, 16'h00A5);
    rd_reg(2'd3, d);
    check("R6 receive read clears full", d, 16'h0001);
  endtask

  task automatic t_direct;
    logic [W-1:0] d, got;
    wr_reg(2'd1, 16'h003C);
    rd_reg(2'd3, d);
    check("R9 direct write keeps tx empty", d, 16'h0001);
    spi_xfer(8, 1'b0, 1'b1, 16'h005A, 99, got);
    check("R9 R3 directly written value sent", got, 16'h003C);
    rd_reg(2'd2, d);
    check("R2 msb-first receive", d, 16'h005A);
  endtask

  task automatic t_retransmit;
    logic [W-1:0] d, got;
    spi_xfer(8, 1'b0, 1'b1, 16'h0011, 99, got);
    check("R11 last received sent back", got, 16'h005A);
    rd_reg(2'd2, d);
    check("R11 receive during retransmit", d, 16'h0011);
  endtask

  task automatic t_held;
    logic [W-1:0] d, got;
    wr_reg(2'd1, 16'h0077);
    wr_reg(2'd1, 16'h0012);
    rd_reg(2'd3, d);
    check("R10 held write clears tx empty", d, 16'h0000);
    wr_reg(2'd1, 16'h0034);
    spi_xfer(8, 1'b0, 1'b1, 16'h0000, 99, got);
    check("R10 newest held value sent", got, 16'h0034);
    rd_reg(2'd3, d);
    check("R10 tx empty after load", d, 16'h0003);
    rd_reg(2'd2, d);
  endtask

  task automatic t_overrun;
    logic [W-1:0] d, got;
    spi_xfer(8, 1'b0, 1'b1, 16'h0001, 99, got);
    spi_xfer(8, 1'b0, 1'b1, 16'h0002, 99, got);
    rd_reg(2'd3, d);
    check("R7 overrun set", d, 16'h0007);
    rd_reg(2'd2, d);
    check("R7 newest word kept", d, 16'h0002);
    rd_reg(2'd3, d);
    check("R8 status read cleared overrun", d, 16'h0001);
  endtask

  task automatic t_wide_cpol1;
    logic [W-1:0] d, got;
    wr_reg(2'd0, 16'h003B);
    wr_reg(2'd1, 16'h0ABC);
    spi_xfer(12, 1'b1, 1'b1, 16'h05C3, 99, got);
    check("R2 R3 12-bit idle-high send", got, 16'h0ABC);
    rd_reg(2'd2, d);
    check("R2 R3 12-bit idle-high receive", d, 16'h05C3);
  endtask

  task automatic t_trailing;
    logic [W-1:0] d, got;
    wr_reg(2'd0, 16'h0007);
    wr_reg(2'd1, 16'h00C6);
    spi_xfer(8, 1'b0, 1'b0, 16'h0039, 99, got);
    check("R4 trailing capture idle-low send", got, 16'h00C6);
    rd_reg(2'd2, d);
    check("R4 trailing capture idle-low receive", d, 16'h0039);
    wr_reg(2'd0, 16'h0017);
    wr_reg(2'd1, 16'h0081);
    spi_xfer(8, 1'b1, 1'b0, 16'h007E, 99, got);
    check("R4 trailing capture idle-high send", got, 16'h0081);
    rd_reg(2'd2, d);
    check("R4 trailing capture idle-high receive", d, 16'h007E);
    spi_xfer(8, 1'b1, 1'b0, 16'h0000, 99, got);
    check("R11 retransmit in trailing mode", got, 16'h007E);
    rd_reg(2'd2, d);
  endtask

  task automatic t_deselected;
    logic [W-1:0] d, got;
    wr_reg(2'd0, 16'h0027);
    spck = 1'b0;
    wait_clk(HALF);
    for (int i = 0; i < 20; i++) begin
      spck = ~spck;
      mosi = i[0];
      wait_clk(HALF);
    end
    rd_reg(2'd3, d);
    check("R5 clock ignored while deselected", d, 16'h0001);
    wr_reg(2'd1, 16'h005A);
    spi_xfer(8, 1'b0, 1'b1, 16'h00E1, 99, got);
    check("R5 later transfer send", got, 16'h005A);
    rd_reg(2'd2, d);
    check("R5 later transfer receive", d, 16'h00E1);
  endtask

  task automatic t_abort;
    logic [W-1:0] d, got;
    wr_reg(2'd1, 16'h0033);
    spi_xfer(8, 1'b0, 1'b1, 16'h00FF, 3, got);
    rd_reg(2'd3, d);
    check("R12 aborted word not received", d, 16'h0001);
    wr_reg(2'd1, 16'h0099);
    rd_reg(2'd3, d);
    check("R12 write after abort is held", d, 16'h0000);
    spi_xfer(8, 1'b0, 1'b1, 16'h0096, 99, got);
    check("R12 held value sent after abort", got, 16'h0099);
    rd_reg(2'd2, d);
    check("R12 full word after abort", d, 16'h0096);
  endtask

  initial begin
    wait_clk(4);
    rst = 1'b0;
    wait_clk(2);
    t_reset();
    t_direct();
    t_retransmit();
    t_held();
    t_overrun();
    t_wide_cpol1();
    t_trailing();
    t_deselected();
    t_abort();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule